// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight wide data registers arranged as a ring and used as a push-down stack. A small pointer names the physical register that is the current top. A push moves the pointer down by one position, wrapping around, and writes the new value there. A pop releases the top register and moves the pointer up by one position. Each physical register also carries a two-bit tag that says whether it is empty or, if it holds a value, what kind of value. The tag is derived from a class code that the producer supplies with each push.

The top and the entry just below it are always readable, so an arithmetic unit next to the block can take both operands in the same cycle. A push onto a register that is still occupied, or a pop of a register that is empty, is refused. The refused command leaves the data, the tags and the pointer as they were. The block then raises a sticky stack-fault flag and an invalid-operation flag, and sets a direction bit that tells an overflow from an underflow. An initialise command empties every register and clears the flags.

Top module: `ring_stack`

## Requirements
- R1: After reset, and one cycle after an initialise command, the top pointer reads 0, the tag word reads 16'hFFFF, and the stack-fault, direction and invalid flags read 0. Initialise does not change the data registers.
- R2: An accepted push sets the top pointer to (top - 1) mod 8 and writes the pushed value into that physical register. The value appears on the top read port in the next cycle. The first push after initialise lands in physical register 7.
- R3: Tag-word bits [2i+1:2i] belong to physical register i, whatever the top pointer is. The codes are 00 = valid non-zero, 01 = zero, 10 = special and 11 = empty. A pushed register takes its code from the class input (00, 01 or 10). A class input of 11 is stored as 10. Pushing a non-zero value and then a zero from the initial state gives 16'h3FFF and then 16'h1FFF.
- R4: An accepted pop sets the old top register's tag to 11 and moves the top pointer to (top + 1) mod 8.
- R5: The second read port always shows the data of physical register (top + 1) mod 8.
- R6: A push whose target register (top - 1) mod 8 is not empty is refused. The top pointer, the tags and the data stay unchanged, and from the next cycle the stack-fault flag, the direction bit and the invalid flag all read 1.
- R7: A pop while the top register's tag is 11 is refused. The top pointer, the tags and the data stay unchanged, and from the next cycle the stack-fault and invalid flags read 1 while the direction bit reads 0.
- R8: The stack-fault and invalid flags stay at 1 until an initialise command. The direction bit always reflects the most recent fault.
- R9: Initialise has priority over push and pop. When push and pop are asserted together without initialise, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialise: empty all registers, pointer to 0, clear flags |
| push_i | input | 1 | Push the value on push_data_i |
| pop_i | input | 1 | Pop the top register |
| push_data_i | input | 80 | Value to push |
| push_class_i | input | 2 | Class of the pushed value, used to form its tag |
| top_ptr_o | output | 3 | Physical index of the current top |
| tag_word_o | output | 16 | Two tag bits per physical register |
| st0_o | output | 80 | Data of the top register |
| st1_o | output | 80 | Data of the register one below the top |
| stack_fault_o | output | 1 | Sticky stack-fault flag |
| c1_o | output | 1 | Direction of the last fault: 1 for push, 0 for pop |
| invalid_o | output | 1 | Sticky invalid-operation flag |

## Verification
A wrong pointer shows at once as a wrong top_ptr_o. On the next cycle the wrong physical register also comes out on st0_o and st1_o. A tag that is written to the wrong slot, or never released, shows in tag_word_o one cycle after the push or pop. Later it shows as a fault that a correct stack would not raise, or as a missing fault, at the next push or pop that reaches that slot. A refused command that still changes state leaves the data read ports out of step with a reference stack from the following cycle on. The bench checks every port after every command, so each of these errors is caught within one cycle of the point where it first becomes visible.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_t;

  // class code 11 has no tag of its own: fold it onto the special tag
  function automatic tag_t class_to_tag(input logic [1:0] cls);
    if (cls == 2'b11) return TAG_SPECIAL;
    return tag_t'(cls);
  endfunction
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              push,
  input  logic              pop,
  input  logic [2*DEPTH-1:0] tag_word,
  output logic [PW-1:0]     top,
  output logic [PW-1:0]     below,
  output logic [PW-1:0]     push_idx,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              fault_ev,
  output logic              sf,
  output logic              c1
);
  import rs_pkg::*;

  function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic push_sel, pop_sel, push_fault, pop_fault;
  logic [1:0] tgt_tag, top_tag;

  assign push_idx = wrap_dec(top);
  assign below    = wrap_inc(top);
  assign tgt_tag  = tag_word[int'(push_idx)*2 +: 2];
  assign top_tag  = tag_word[int'(top)*2 +: 2];

  // init wins over everything, push wins over pop
  assign push_sel   = push & ~init;
  assign pop_sel    = pop & ~push & ~init;
  assign push_fault = push_sel & (tgt_tag != TAG_EMPTY);
  assign pop_fault  = pop_sel & (top_tag == TAG_EMPTY);
  assign push_ok    = push_sel & ~push_fault;
  assign pop_ok     = pop_sel & ~pop_fault;
  assign fault_ev   = push_fault | pop_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top <= '0;
      sf  <= 1'b0;
      c1  <= 1'b0;
    end else if (init) begin
      top <= '0;
      sf  <= 1'b0;
      c1  <= 1'b0;
    end else begin
      if (push_ok)     top <= push_idx;
      else if (pop_ok) top <= below;
      if (fault_ev) begin
        sf <= 1'b1;
        c1 <= push_fault;
      end
    end
  end
endmodule

// File: rtl/rs_tags.sv
module rs_tags #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               wr_en,
  input  logic [PW-1:0]      wr_idx,
  input  logic [1:0]         wr_class,
  input  logic               clr_en,
  input  logic [PW-1:0]      clr_idx,
  output logic [2*DEPTH-1:0] tag_word
);
  import rs_pkg::*;

  tag_t new_tag;
  assign new_tag = class_to_tag(wr_class);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    tag_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slot_q <= TAG_EMPTY;
      else if (init)                             slot_q <= TAG_EMPTY;
      else if (wr_en && wr_idx == PW'(i))        slot_q <= new_tag;
      else if (clr_en && clr_idx == PW'(i))      slot_q <= TAG_EMPTY;
    end
    assign tag_word[2*i +: 2] = slot_q;
  end
endmodule

// File: rtl/rs_file.sv
module rs_file #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PW-1:0]    widx,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PW-1:0]    ridx0,
  input  logic [PW-1:0]    ridx1,
  output logic [WIDTH-1:0] rdata0,
  output logic [WIDTH-1:0] rdata1
);
  logic [WIDTH-1:0] regs [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[i] <= '0;
      else if (we && widx == PW'(i))     regs[i] <= wdata;
    end
  end

  assign rdata0 = regs[ridx0];
  assign rdata1 = regs[ridx1];
endmodule

// File: rtl/ring_stack.sv
module ring_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_i,
  input  logic               push_i,
  input  logic               pop_i,
  input  logic [WIDTH-1:0]   push_data_i,
  input  logic [1:0]         push_class_i,
  output logic [PW-1:0]      top_ptr_o,
  output logic [2*DEPTH-1:0] tag_word_o,
  output logic [WIDTH-1:0]   st0_o,
  output logic [WIDTH-1:0]   st1_o,
  output logic               stack_fault_o,
  output logic               c1_o,
  output logic               invalid_o
);
  logic [PW-1:0] below, push_idx;
  logic push_ok, pop_ok, fault_ev;

  rs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .init(init_i), .push(push_i), .pop(pop_i),
    .tag_word(tag_word_o), .top(top_ptr_o), .below(below), .push_idx(push_idx),
    .push_ok(push_ok), .pop_ok(pop_ok), .fault_ev(fault_ev),
    .sf(stack_fault_o), .c1(c1_o)
  );

  rs_tags #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n), .init(init_i),
    .wr_en(push_ok), .wr_idx(push_idx), .wr_class(push_class_i),
    .clr_en(pop_ok), .clr_idx(top_ptr_o), .tag_word(tag_word_o)
  );

  rs_file #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_file (
    .clk(clk), .rst_n(rst_n), .we(push_ok), .widx(push_idx),
    .wdata(push_data_i), .ridx0(top_ptr_o), .ridx1(below),
    .rdata0(st0_o), .rdata1(st1_o)
  );

  // every fault this block can raise is an invalid operation
  assign invalid_o = stack_fault_o;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_i,
  input logic               push_i,
  input logic               pop_i,
  input logic [PW-1:0]      top_ptr_o,
  input logic [2*DEPTH-1:0] tag_word_o,
  input logic               stack_fault_o,
  input logic               c1_o,
  input logic               invalid_o,
  input logic               push_ok,
  input logic               pop_ok,
  input logic               fault_ev
);
  p_init_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (top_ptr_o == '0) && (&tag_word_o) && !stack_fault_o && !c1_o && !invalid_o);

  p_push_moves_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> top_ptr_o == PW'($past(top_ptr_o) - 1'b1));

  p_push_tag_filled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> tag_word_o[int'(top_ptr_o)*2 +: 2] != 2'b11);

  p_pop_moves_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> top_ptr_o == PW'($past(top_ptr_o) + 1'b1));

  p_fault_holds_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> $stable(tag_word_o) && $stable(top_ptr_o));

  p_push_fault_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && push_i) |=> stack_fault_o && c1_o && invalid_o);

  p_pop_fault_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_ev && !push_i) |=> stack_fault_o && !c1_o && invalid_o);

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_fault_o && !init_i) |=> stack_fault_o);

  p_push_beats_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i) |-> !pop_ok);
endmodule

bind ring_stack rs_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/ring_stack_test.sv
module ring_stack_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_i = 0, push_i = 0, pop_i = 0;
  logic [79:0] push_data_i = '0;
  logic [1:0]  push_class_i = '0;
  logic [2:0]  top_ptr_o;
  logic [15:0] tag_word_o;
  logic [79:0] st0_o, st1_o;
  logic stack_fault_o, c1_o, invalid_o;

  int n_tests = 0, n_fail = 0;

  // reference model
  logic [79:0] m_data [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;
  logic m_sf, m_c1;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_stack uut (.*);

  function automatic logic [1:0] exp_tag(input logic [1:0] cls);
    return (cls == 2'd3) ? 2'd2 : cls;
  endfunction

  function automatic logic [15:0] exp_word();
    logic [15:0] w;
    for (int i = 0; i < 8; i++) w[2*i +: 2] = m_tag[i];
    return w;
  endfunction

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 R4 top pointer", 80'(top_ptr_o), 80'(m_top));
    chk("R3 tag word", 80'(tag_word_o), 80'(exp_word()));
    chk("R2 top data", st0_o, m_data[m_top]);
    chk("R5 below data", st1_o, m_data[3'(m_top + 3'd1)]);
    chk("R6 R7 R8 stack fault", 80'(stack_fault_o), 80'(m_sf));
    chk("R8 direction bit", 80'(c1_o), 80'(m_c1));
    chk("R6 invalid flag", 80'(invalid_o), 80'(m_sf));
  endtask

  task automatic model_init();
    for (int i = 0; i < 8; i++) m_tag[i] = 2'd3;
    m_top = '0; m_sf = 0; m_c1 = 0;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic op(input logic in, input logic pu, input logic po,
                    input logic [79:0] d, input logic [1:0] cls);
    logic [2:0] n;
    init_i = in; push_i = pu; pop_i = po; push_data_i = d; push_class_i = cls;
    if (in) model_init();
    else if (pu) begin
      n = m_top - 3'd1;
      if (m_tag[n] != 2'd3) begin m_sf = 1; m_c1 = 1; end
      else begin m_data[n] = d; m_tag[n] = exp_tag(cls); m_top = n; end
    end else if (po) begin
      if (m_tag[m_top] == 2'd3) begin m_sf = 1; m_c1 = 0; end
      else begin m_tag[m_top] = 2'd3; m_top = m_top + 3'd1; end
    end
    @(negedge clk);
    init_i = 0; push_i = 0; pop_i = 0;
    compare_all();
  endtask

  function automatic logic [79:0] rnd80();
    return {$urandom(), $urandom(), 16'($urandom())};
  endfunction

  initial begin
    #(CLK_PERIOD * 5000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) m_data[i] = '0;
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all();                                    // R1 reset state

    op(0, 1, 0, 80'h4002_A000_0000_0000_0000, 2'd0);  // R2 lands in R7
    chk("R2 first push in slot 7", 80'(top_ptr_o), 80'd7);
    chk("R3 word after nonzero push", 80'(tag_word_o), 80'h3FFF);
    op(0, 1, 0, 80'h0, 2'd1);
    chk("R3 word after zero push", 80'(tag_word_o), 80'h1FFF);
    op(0, 1, 0, rnd80(), 2'd2);                       // R3 special
    op(0, 1, 0, rnd80(), 2'd3);                       // R3 class 11 -> 10
    chk("R3 class 11 stored as special", 80'(tag_word_o[9:8]), 80'd2);
    for (int k = 0; k < 4; k++) op(0, 1, 0, rnd80(), 2'($urandom()));
    chk("R2 wrap to slot 0", 80'(top_ptr_o), 80'd0);
    op(0, 1, 0, rnd80(), 2'd0);                       // R6 overflow
    chk("R6 overflow sets C1", 80'(c1_o), 80'd1);
    op(0, 1, 1, rnd80(), 2'd0);                       // R9 push wins, still faults
    for (int k = 0; k < 8; k++) op(0, 0, 1, '0, 2'd0); // R4 pops
    chk("R4 all empty", 80'(tag_word_o), 80'hFFFF);
    op(0, 0, 1, '0, 2'd0);                            // R7 underflow
    chk("R7 underflow clears C1", 80'(c1_o), 80'd0);
    op(0, 0, 0, '0, 2'd0);
    chk("R8 fault sticky", 80'(stack_fault_o), 80'd1);
    op(1, 1, 1, rnd80(), 2'd0);                       // R9 init wins, R1
    chk("R1 init clears fault", 80'(stack_fault_o), 80'd0);
    op(0, 1, 1, 80'h1234, 2'd1);                      // R9 push over pop
    chk("R9 push taken", 80'(st0_o), 80'h1234);

    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom() % 32);
      if (r == 0)       op(1, 0, 0, '0, 2'd0);
      else if (r < 15)  op(0, 1, 0, rnd80(), 2'($urandom()));
      else if (r == 31) op(0, 1, 1, rnd80(), 2'($urandom()));
      else              op(0, 0, 1, '0, 2'd0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule